// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous static memory whose data phase always trails its command by one clock. Address, direction, lane enables and the three chip-select inputs are registered on a rising edge. The matching transfer uses the data bus during the cycle that follows. A read drives array contents straight onto the output with no output register. Write data is taken on the edge that closes the data cycle. Reads and writes can be interleaved on consecutive cycles with no idle slot between them.

A four-beat burst can be started from one address. A separate sequencer walks the two low address bits in linear or interleaved order, and keeps the direction chosen at load. A clock-enable input freezes the whole pipeline for any number of edges. A deselect stops any burst but still lets the transfer already in flight finish. An asynchronous output enable can float the bus at any moment.

Writes are first held in a one-entry posted-write stage and reach the array on the next enabled edge. A read of the same word in the cycle right after a write sees the new lanes through forwarding.

Top module: `zt_sram`

## Requirements
- R1: On an enabled edge (clkEn_n=0) with advLd=0 and the chip selected, a command is captured, and its data transfer uses the bus in the very next cycle.
- R2: The word for a read captured at edge n appears on dataOut with dataOutEn=1 throughout cycle n+1, taken straight from storage with no extra register stage.
- R3: An edge with clkEn_n=1 is ignored: every input is disregarded, and dataOut, dataOutEn and the stored words keep their values.
- R4: The chip counts as selected only when selA_n=0, selB_n=0 and selC=1. Any other combination with advLd=0 on an enabled edge starts a deselect, and dataOutEn is 0 in the next cycle.
- R5: After a write command or a deselect is captured, dataOutEn is 0 in the next cycle, and a transfer pending from the previous command still completes.
- R6: With advLd=1 during a burst, addrIn and rdWr are ignored, the burst keeps the direction captured at load, and it moves on to the next address.
- R7: A burst alters only the two low address bits, starting from the loaded value s. With interleave=0 beat k uses (s+k) mod 4. With interleave=1 it uses s XOR k. After four beats the sequence wraps to s and continues.
- R8: A deselect ends a burst in progress. A later edge with advLd=1 is then a no-op that leaves dataOutEn at 0.
- R9: byteWe_n[i]=0 writes lane i, which is dataIn[9i+8:9i]. Lanes with byteWe_n[i]=1 keep their old contents. Any mix of lanes may be written in one cycle, and byteWe_n has no effect on reads.
- R10: Write data is sampled on the enabled edge that ends the write's data cycle. A stalled edge in between does not sample it.
- R11: outEn_n=1 forces dataOutEn to 0 immediately, whatever the pipeline state.
- R12: A read captured on the data cycle of a write to the same address returns the newly written lanes merged with the unwritten old lanes.
- R13: A synchronous reset (rst=1) clears the pending transfer and any active burst, so dataOutEn is 0 after reset.
- R14: Write, read, write, read on consecutive cycles runs with no dead cycle, and each read returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clkEn_n | input | 1 | Clock enable, active low; high freezes the edge |
| selA_n | input | 1 | Chip select, active low |
| selB_n | input | 1 | Chip select, active low |
| selC | input | 1 | Chip select, active high |
| advLd | input | 1 | 0 loads a new command, 1 advances the burst |
| rdWr | input | 1 | 1 read, 0 write; sampled at load only |
| byteWe_n | input | 4 | Per-lane write enables, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| outEn_n | input | 1 | Asynchronous output enable, active low |
| dataOut | output | 36 | Read data, zero when not driving |
| dataOutEn | output | 1 | High when dataOut should drive the bus |

## Verification
Two events can land in the same cycle: a write's data is committed into the posted-write stage while a read of that same word is being captured. The bench provokes this by issuing a read to the written address on the write's own data cycle. It uses full-lane and partial-lane writes, so the output must mix forwarded and stored lanes. The output in the following cycle is compared lane by lane with the expected mix, and the word is read again later to confirm that the array itself received the merge.

// File: rtl/zt_pkg.sv
package zt_pkg;
  parameter int unsigned LANES  = 4;
  parameter int unsigned LANE_W = 9;
  parameter int unsigned DATA_W = LANES * LANE_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic             edgeOn;   // this edge is not frozen
    logic             commitWr; // write data of pending command is sampled now
    logic             readOut;  // pending read owns the data cycle
    logic [LANES-1:0] laneWe;   // active-high lane enables of pending write
  } zt_strobe_t;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] curAddr
);
  logic [ADDR_W-1:0]  baseQ;
  logic [BURST_W-1:0] cntQ;
  logic [BURST_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (load) begin
      baseQ <= startAddr;
      cntQ  <= '0;
    end else if (step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  always_comb begin
    if (interleave) lowBits = baseQ[BURST_W-1:0] ^ cntQ;
    else            lowBits = baseQ[BURST_W-1:0] + cntQ;
  end

  assign curAddr = {baseQ[ADDR_W-1:BURST_W], lowBits};
endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clkEn_n,
  input  logic             selA_n,
  input  logic             selB_n,
  input  logic             selC,
  input  logic             advLd,
  input  logic             rdWr,
  input  logic [LANES-1:0] byteWe_n,
  input  logic             outEn_n,
  output zt_strobe_t       strobe,
  output logic             seqLoad,
  output logic             seqStep,
  output logic             outDrive
);
  logic             selected;
  logic             edgeOn;
  logic             pendValidQ;
  logic             pendReadQ;
  logic             burstActQ;
  logic             burstReadQ;
  logic [LANES-1:0] pendBeQ;

  assign selected = !selA_n && !selB_n && selC;
  assign edgeOn   = !clkEn_n;
  assign seqLoad  = edgeOn && !advLd && selected;
  assign seqStep  = edgeOn && advLd && burstActQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValidQ <= 1'b0;
      pendReadQ  <= 1'b0;
      burstActQ  <= 1'b0;
      burstReadQ <= 1'b0;
      pendBeQ    <= '1;
    end else if (edgeOn) begin
      if (!advLd) begin
        if (selected) begin
          pendValidQ <= 1'b1;
          pendReadQ  <= rdWr;
          burstActQ  <= 1'b1;
          burstReadQ <= rdWr;
          pendBeQ    <= byteWe_n;
        end else begin
          pendValidQ <= 1'b0;
          burstActQ  <= 1'b0;
        end
      end else if (burstActQ) begin
        pendValidQ <= 1'b1;
        pendReadQ  <= burstReadQ;
        pendBeQ    <= byteWe_n;
      end else begin
        pendValidQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.edgeOn   = edgeOn;
    strobe.commitWr = edgeOn && pendValidQ && !pendReadQ;
    strobe.readOut  = pendValidQ && pendReadQ;
    strobe.laneWe   = ~pendBeQ;
  end

  assign outDrive = pendValidQ && pendReadQ && !outEn_n;
endmodule

// File: rtl/zt_datapath.sv
module zt_datapath
  import zt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  zt_strobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic              wbValid;
  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;
  logic [LANES-1:0]  wbBe;
  logic              wbHit;
  logic [DATA_W-1:0] rdWord;

  // Posted-write stage: write data lands here, the array follows next edge
  always_ff @(posedge clk) begin
    if (rst)                wbValid <= 1'b0;
    else if (strobe.edgeOn) wbValid <= strobe.commitWr;
  end

  always_ff @(posedge clk) begin
    if (strobe.commitWr) begin
      wbAddr <= rdAddr;
      wbData <= dataIn;
      wbBe   <= strobe.laneWe;
    end
  end

  assign wbHit = wbValid && (wbAddr == rdAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst && strobe.edgeOn && wbValid && wbBe[g])
        laneMem[wbAddr] <= wbData[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = (wbHit && wbBe[g]) ?
        wbData[g*LANE_W +: LANE_W] : laneMem[rdAddr];
  end

  assign dataOut = strobe.readOut ? rdWord : '0;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn_n,
  input  logic              selA_n,
  input  logic              selB_n,
  input  logic              selC,
  input  logic              advLd,
  input  logic              rdWr,
  input  logic [LANES-1:0]  byteWe_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEn_n,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  zt_strobe_t        strobe;
  logic              seqLoad;
  logic              seqStep;
  logic [ADDR_W-1:0] curAddr;

  zt_ctrl i_ctrl (
    .clk(clk), .rst(rst), .clkEn_n(clkEn_n),
    .selA_n(selA_n), .selB_n(selB_n), .selC(selC),
    .advLd(advLd), .rdWr(rdWr), .byteWe_n(byteWe_n), .outEn_n(outEn_n),
    .strobe(strobe), .seqLoad(seqLoad), .seqStep(seqStep), .outDrive(dataOutEn)
  );

  zt_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_seq (
    .clk(clk), .rst(rst), .load(seqLoad), .step(seqStep),
    .interleave(interleave), .startAddr(addrIn), .curAddr(curAddr)
  );

  zt_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdAddr(curAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEn_n,
  input logic              selA_n,
  input logic              selB_n,
  input logic              selC,
  input logic              advLd,
  input logic              rdWr,
  input logic              outEn_n,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn
);
  logic sel;
  assign sel = !selA_n && !selB_n && selC;

  a_r1_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!clkEn_n && !advLd && sel && rdWr) |=> (dataOutEn || outEn_n));

  a_r5_write_floats: assert property (@(posedge clk) disable iff (rst)
    (!clkEn_n && !advLd && sel && !rdWr) |=> !dataOutEn);

  a_r4_deselect_floats: assert property (@(posedge clk) disable iff (rst)
    (!clkEn_n && !advLd && !sel) |=> !dataOutEn);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
    clkEn_n |=> $stable(dataOut));

  a_r11_oe_floats: assert property (@(posedge clk) disable iff (rst)
    outEn_n |-> !dataOutEn);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(zt_pkg::DATA_W)) i_chk (
  .clk(clk), .rst(rst), .clkEn_n(clkEn_n), .selA_n(selA_n), .selB_n(selB_n),
  .selC(selC), .advLd(advLd), .rdWr(rdWr), .outEn_n(outEn_n),
  .dataOut(dataOut), .dataOutEn(dataOutEn)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam int unsigned AW = 8;
  localparam logic [2:0] SEL  = 3'b001; // {selA_n, selB_n, selC}
  localparam logic [3:0] ALL  = 4'b0000;
  localparam logic [3:0] NONE = 4'b1111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clkEn_n = 1'b0;
  logic        selA_n = 1'b1, selB_n = 1'b0, selC = 1'b1;
  logic        advLd = 1'b0, rdWr = 1'b1;
  logic [3:0]  byteWe_n = NONE;
  logic        interleave = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [35:0] dataIn = '0;
  logic        outEn_n = 1'b0;
  logic [35:0] dataOut;
  logic        dataOutEn;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zt_sram #(.ADDR_W(AW)) i_zt_sram (
    .clk(clk), .rst(rst), .clkEn_n(clkEn_n), .selA_n(selA_n), .selB_n(selB_n),
    .selC(selC), .advLd(advLd), .rdWr(rdWr), .byteWe_n(byteWe_n),
    .interleave(interleave), .addrIn(addrIn), .dataIn(dataIn),
    .outEn_n(outEn_n), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  localparam logic [35:0] D1 = 36'h1_1111_2222, DA = 36'hA_5A5A_0F0F;
  localparam logic [35:0] DB = 36'h3_3C3C_7E7E, DC = 36'h5_0123_4567;
  localparam logic [35:0] OLD = 36'h2_4681_ACE0, NEW = 36'hC_BDF1_3579;
  localparam logic [35:0] LMASK = 36'h0_07FC_01FF; // lanes 0 and 2
  localparam logic [35:0] W0 = 36'h0_1000_0001, W1 = 36'h0_2000_0002;
  localparam logic [35:0] W2 = 36'h0_3000_0003, W3 = 36'h0_4000_0004;
  localparam logic [35:0] GOOD = 36'h7_7777_8888, JUNK = 36'hF_FFFF_FFFF;
  localparam logic [35:0] DE = 36'h9_ABCD_EF01;

  task automatic go(input logic adv, input logic rw, input logic [2:0] cs,
                    input logic [3:0] be, input logic [AW-1:0] a,
                    input logic [35:0] d, input logic stall);
    advLd = adv; rdWr = rw; {selA_n, selB_n, selC} = cs;
    byteWe_n = be; addrIn = a; dataIn = d; clkEn_n = stall;
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic chkRd(input string tag, input logic [35:0] exp);
    nChk++;
    if (dataOutEn !== 1'b1 || dataOut !== exp) begin
      nFail++;
      $display("FAIL %s: en=%0b data=%h, expected en=1 data=%h", tag, dataOutEn, dataOut, exp);
    end
  endtask

  task automatic chkZ(input string tag);
    nChk++;
    if (dataOutEn !== 1'b0) begin
      nFail++;
      $display("FAIL %s: en=%0b, expected en=0", tag, dataOutEn);
    end
  endtask

  task automatic desel();
    go(0, 1, 3'b101, ALL, '0, '0, 0);
  endtask

  task automatic t_reset();
    repeat (3) begin @(negedge clk); end
    #1; rst = 1'b0;
    advLd = 1'b1;
    @(negedge clk); #1;
    chkZ("R13 after reset");
  endtask

  task automatic t_write_read();
    go(0, 0, SEL, ALL, 8'h20, '0, 0);
    chkZ("R5 write data cycle");
    go(0, 1, SEL, ALL, 8'h20, D1, 0);
    chkRd("R12 read right after write", D1);
    desel();
    chkZ("R8 after deselect");
    go(0, 1, SEL, ALL, 8'h20, '0, 0);
    chkRd("R2 array read", D1);
    desel();
  endtask

  task automatic t_alternate();
    go(0, 0, SEL, ALL, 8'h30, '0, 0);  chkZ("R14 w30");
    go(0, 1, SEL, ALL, 8'h20, DA, 0);  chkRd("R14 r20", D1);
    go(0, 0, SEL, ALL, 8'h31, '0, 0);  chkZ("R14 w31");
    go(0, 1, SEL, ALL, 8'h30, DB, 0);  chkRd("R14 r30", DA);
    go(0, 0, SEL, ALL, 8'h32, '0, 0);  chkZ("R14 w32");
    go(0, 1, SEL, ALL, 8'h31, DC, 0);  chkRd("R14 r31", DB);
    desel();
    go(0, 1, SEL, ALL, 8'h32, '0, 0);  chkRd("R1 r32", DC);
    desel();
  endtask

  task automatic t_lanes();
    logic [35:0] mix;
    mix = (NEW & LMASK) | (OLD & ~LMASK);
    go(0, 0, SEL, ALL, 8'h40, '0, 0);
    go(0, 0, SEL, 4'b1010, 8'h40, OLD, 0);
    go(0, 1, SEL, NONE, 8'h40, NEW, 0);
    chkRd("R12 merged forward", mix);
    desel();
    go(0, 1, SEL, ALL, 8'h40, '0, 0);
    chkRd("R9 merged in array", mix);
    go(0, 0, SEL, NONE, 8'h40, '0, 0);
    go(0, 1, SEL, ALL, 8'h40, JUNK, 0);
    chkRd("R9 no lanes enabled", mix);
    desel();
  endtask

  task automatic t_burst();
    interleave = 1'b0;
    go(0, 0, SEL, ALL, 8'h51, '0, 0);
    go(1, 1, SEL, ALL, 8'hFF, W0, 0);  chkZ("R6 burst write stays write");
    go(1, 1, SEL, ALL, 8'hFF, W1, 0);
    go(1, 1, SEL, ALL, 8'hFF, W2, 0);
    go(0, 1, 3'b101, ALL, '0, W3, 0);
    go(0, 1, SEL, ALL, 8'h52, '0, 0);  chkRd("R7 linear beat0", W1);
    go(1, 0, SEL, ALL, 8'h00, '0, 0);  chkRd("R6 linear beat1 ignores rdWr", W2);
    go(1, 0, SEL, ALL, 8'h00, '0, 0);  chkRd("R7 linear beat2", W3);
    go(1, 0, SEL, ALL, 8'h00, '0, 0);  chkRd("R7 linear beat3", W0);
    go(1, 0, SEL, ALL, 8'h00, '0, 0);  chkRd("R7 linear wrap", W1);
    desel();
    interleave = 1'b1;
    go(0, 1, SEL, ALL, 8'h51, '0, 0);  chkRd("R7 interleaved beat0", W0);
    go(1, 1, SEL, ALL, 8'h00, '0, 0);  chkRd("R7 interleaved beat1", W3);
    go(1, 1, SEL, ALL, 8'h00, '0, 0);  chkRd("R7 interleaved beat2", W2);
    go(1, 1, SEL, ALL, 8'h00, '0, 0);  chkRd("R7 interleaved beat3", W1);
    desel();
    interleave = 1'b0;
  endtask

  task automatic t_stall();
    go(0, 1, SEL, ALL, 8'h20, '0, 0);  chkRd("R3 before stall", D1);
    go(0, 0, SEL, ALL, 8'h30, JUNK, 1); chkRd("R3 stall 1", D1);
    go(0, 1, SEL, ALL, 8'h30, JUNK, 1); chkRd("R3 stall 2", D1);
    go(0, 1, SEL, ALL, 8'h30, '0, 0);  chkRd("R3 stored word untouched", DA);
    go(0, 0, SEL, ALL, 8'h60, '0, 0);
    go(1, 1, 3'b101, ALL, '0, JUNK, 1);
    go(0, 1, 3'b101, ALL, '0, GOOD, 0);
    go(0, 1, SEL, ALL, 8'h60, '0, 0);  chkRd("R10 data after stall", GOOD);
    desel();
  endtask

  task automatic t_deselect();
    go(0, 1, SEL, ALL, 8'h20, '0, 0);  chkRd("R4 read", D1);
    go(0, 1, 3'b101, ALL, 8'h20, '0, 0); chkZ("R4 selA_n high");
    go(0, 1, SEL, ALL, 8'h20, '0, 0);
    go(0, 1, 3'b011, ALL, 8'h20, '0, 0); chkZ("R4 selB_n high");
    go(0, 1, SEL, ALL, 8'h20, '0, 0);
    go(0, 1, 3'b000, ALL, 8'h20, '0, 0); chkZ("R4 selC low");
    go(1, 1, SEL, ALL, 8'h20, '0, 0);  chkZ("R8 noop after deselect");
    go(0, 0, SEL, ALL, 8'h70, '0, 0);
    go(0, 1, 3'b000, ALL, '0, DE, 0);
    go(0, 1, SEL, ALL, 8'h70, '0, 0);  chkRd("R5 pending write completed", DE);
    desel();
  endtask

  task automatic t_oe();
    go(0, 1, SEL, ALL, 8'h20, '0, 0);
    outEn_n = 1'b1; #1;
    chkZ("R11 oe high");
    outEn_n = 1'b0; #1;
    chkRd("R11 oe low again", D1);
    desel();
  endtask

  task automatic t_reset_mid();
    go(0, 1, SEL, ALL, 8'h51, '0, 0);
    rst = 1'b1;
    go(1, 1, SEL, ALL, '0, '0, 0);
    rst = 1'b0;
    chkZ("R13 reset mid burst");
    go(1, 1, SEL, ALL, '0, '0, 0);
    chkZ("R13 burst cleared");
  endtask

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_write_read();
    t_alternate();
    t_lanes();
    t_burst();
    t_stall();
    t_deselect();
    t_oe();
    t_reset_mid();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule